// File: doc/BRIEF.md
# Slow Line Store with Acknowledge

This block stands in for a large, slow backing store behind a data cache. It holds whole 256-bit lines and serves one line per request. The cache side raises an enable together with a direction flag, a 32-bit byte address and, for stores, a full line of write data. The store samples that request, stays busy for a fixed number of cycles, and then raises a one-cycle acknowledge. For a load, the requested line is on the read-data output in the acknowledge cycle. For a store, the whole line is committed on the same clock edge that raises the acknowledge.

Typical use is line fills and dirty-victim write-backs from a write-back, write-allocate cache. The controller can hold enable high until it sees the acknowledge. The store accepts only one request at a time. Anything presented while an access is in flight, or during the acknowledge cycle itself, is dropped. The latency, line width and number of stored lines are parameters.

Top module: `lat_line_mem`

## Requirements
- R1: During and after reset, `mem_ack_o` is 0 and `mem_rdata_o` is all zeros until the first load is acknowledged.
- R2: A request is accepted on a clock edge where `mem_en_i` is 1 and the store is idle. `mem_ack_o` is then 1 for exactly one cycle, becoming visible LATENCY (default 10) cycles after the accepting edge.
- R3: For a load (`mem_wr_i` = 0), `mem_rdata_o` in the acknowledge cycle equals the last line stored at the same line index. It holds that value until the next load is acknowledged.
- R4: For a store (`mem_wr_i` = 1), all LINE_W bits of `mem_wdata_i` sampled at acceptance are committed at the acknowledge edge. A later load of that index returns them unchanged.
- R5: The line index is address bits [5 +: log2(DEPTH)], which is [13:5] for the default 512 lines. Bits [4:0] and the bits above the index are ignored, so addresses differing only there reach the same line.
- R6: While an access is in flight, changes on `mem_en_i`, `mem_wr_i`, `mem_addr_i` and `mem_wdata_i` have no effect. The access completes with the values sampled at acceptance, and no extra acknowledge results.
- R7: A request presented in the acknowledge cycle is ignored. With enable held high, accepted requests are spaced LATENCY+2 cycles apart.
- R8: A store acknowledge leaves `mem_rdata_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_en_i | input | 1 | Request strobe, sampled only while idle |
| mem_wr_i | input | 1 | 1 = store line, 0 = load line |
| mem_addr_i | input | 32 | Byte address; line index taken from bits above the line offset |
| mem_wdata_i | input | 256 | Line to store |
| mem_rdata_o | output | 256 | Line returned by the latest load |
| mem_ack_o | output | 1 | One-cycle completion pulse |

## Verification
Every result of this block is due at one predictable point: the acknowledge and its read data appear LATENCY cycles after the accepting edge. When enable is held high, the next acknowledge follows LATENCY+2 cycles after that. For each request, the driver records the cycle count at the edge that accepts it and queues the due cycle and expected line. The monitor samples on falling edges only. It matches every acknowledge against the head of the queue, both for its cycle number and for its data. Any acknowledge with nothing queued is a failure, which is how ignored requests and noisy inputs during busy periods are caught.

// File: rtl/lat_line_mem_pkg.sv
package lat_line_mem_pkg;

  localparam int unsigned ADDR_W_DEF  = 32;
  localparam int unsigned LINE_W_DEF  = 256;
  localparam int unsigned DEPTH_DEF   = 512;
  localparam int unsigned LATENCY_DEF = 10;

  // bits needed to hold a down-counter loaded with the latency
  function automatic int unsigned cnt_bits(int unsigned lat);
    return (lat < 1) ? 1 : $clog2(lat + 1);
  endfunction

  // byte-offset bits inside one line
  function automatic int unsigned off_bits(int unsigned line_w);
    return $clog2(line_w / 8);
  endfunction

endpackage

// File: rtl/lmem_rst_sync.sv
module lmem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/lmem_timer.sv
module lmem_timer #(
  parameter int unsigned LATENCY = 10,
  parameter int unsigned CNT_W   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic accept_o,
  output logic fire_o,
  output logic ack_o
);

  logic [CNT_W-1:0] remain_q, remain_d;
  logic             ack_q, ack_d;
  logic             idle;

  // idle only when no count is running and no acknowledge is showing
  always_comb begin
    idle     = (remain_q == '0) && !ack_q;
    accept_o = req_i && idle;
    fire_o   = (remain_q == CNT_W'(1));
    remain_d = remain_q;
    if (accept_o) begin
      remain_d = CNT_W'(LATENCY);
    end else if (remain_q != '0) begin
      remain_d = remain_q - CNT_W'(1);
    end
    ack_d = fire_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      ack_q    <= 1'b0;
    end else begin
      remain_q <= remain_d;
      ack_q    <= ack_d;
    end
  end

  assign ack_o = ack_q;

endmodule

// File: rtl/lmem_req_latch.sv
module lmem_req_latch #(
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LINE_W-1:0] wdata_i,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [LINE_W-1:0] wdata_o
);

  logic              wr_q, wr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [LINE_W-1:0] wdata_q, wdata_d;

  always_comb begin
    wr_d    = wr_q;
    idx_d   = idx_q;
    wdata_d = wdata_q;
    if (load_i) begin
      wr_d    = wr_i;
      idx_d   = idx_i;
      wdata_d = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      wr_q  <= wr_d;
      idx_q <= idx_d;
    end
  end

  // wide payload register carries no reset; it is loaded before first use
  always_ff @(posedge clk) begin
    wdata_q <= wdata_d;
  end

  assign wr_o    = wr_q;
  assign idx_o   = idx_q;
  assign wdata_o = wdata_q;

endmodule

// File: rtl/lmem_array.sv
module lmem_array #(
  parameter int unsigned DEPTH  = 512,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned LINE_W = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [LINE_W-1:0] wdata_i,
  output logic [LINE_W-1:0] rdata_o
);

  logic [LINE_W-1:0] store_q [DEPTH];
  logic [LINE_W-1:0] rdata_q, rdata_d;
  logic              wr_en, rd_en;

  always_comb begin
    wr_en   = fire_i && wr_i;
    rd_en   = fire_i && !wr_i;
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = store_q[idx_i];
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      store_q[idx_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/lat_line_mem.sv
module lat_line_mem
  import lat_line_mem_pkg::*;
#(
  parameter int unsigned ADDR_W  = ADDR_W_DEF,
  parameter int unsigned LINE_W  = LINE_W_DEF,
  parameter int unsigned DEPTH   = DEPTH_DEF,
  parameter int unsigned LATENCY = LATENCY_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mem_en_i,
  input  logic              mem_wr_i,
  input  logic [ADDR_W-1:0] mem_addr_i,
  input  logic [LINE_W-1:0] mem_wdata_i,
  output logic [LINE_W-1:0] mem_rdata_o,
  output logic              mem_ack_o
);

  localparam int unsigned OFF_W = off_bits(LINE_W);
  localparam int unsigned IDX_W = (DEPTH < 2) ? 1 : $clog2(DEPTH);
  localparam int unsigned CNT_W = cnt_bits(LATENCY);

  logic              rst_n_int;
  logic              accept;
  logic              fire;
  logic              acc_wr_q;
  logic [IDX_W-1:0]  acc_idx_q;
  logic [LINE_W-1:0] acc_wdata_q;
  logic [IDX_W-1:0]  req_idx;

  assign req_idx = mem_addr_i[OFF_W +: IDX_W];

  // address bits outside the index select nothing
  generate
    if (OFF_W + IDX_W < ADDR_W) begin : g_hi_bits
      logic addr_unused;
      assign addr_unused = ^{mem_addr_i[ADDR_W-1:OFF_W+IDX_W], mem_addr_i[OFF_W-1:0]};
    end else begin : g_no_hi_bits
      logic addr_unused;
      assign addr_unused = ^mem_addr_i[OFF_W-1:0];
    end
  endgenerate

  lmem_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  lmem_timer #(
    .LATENCY (LATENCY),
    .CNT_W   (CNT_W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .req_i    (mem_en_i),
    .accept_o (accept),
    .fire_o   (fire),
    .ack_o    (mem_ack_o)
  );

  lmem_req_latch #(
    .IDX_W  (IDX_W),
    .LINE_W (LINE_W)
  ) u_req (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .load_i  (accept),
    .wr_i    (mem_wr_i),
    .idx_i   (req_idx),
    .wdata_i (mem_wdata_i),
    .wr_o    (acc_wr_q),
    .idx_o   (acc_idx_q),
    .wdata_o (acc_wdata_q)
  );

  lmem_array #(
    .DEPTH  (DEPTH),
    .IDX_W  (IDX_W),
    .LINE_W (LINE_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .fire_i  (fire),
    .wr_i    (acc_wr_q),
    .idx_i   (acc_idx_q),
    .wdata_i (acc_wdata_q),
    .rdata_o (mem_rdata_o)
  );

endmodule

// File: rtl/lat_line_mem_chk.sv
module lat_line_mem_chk #(
  parameter int unsigned LATENCY = 10,
  parameter int unsigned LINE_W  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic              ack_o,
  input logic              acc_wr,
  input logic [LINE_W-1:0] rdata_o
);

  localparam int unsigned GAP_W   = $clog2(LATENCY + 3) + 1;
  localparam int unsigned GAP_MIN = LATENCY + 1;

  logic [GAP_W-1:0] since_ack_q;
  logic             en_seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_ack_q <= GAP_W'(GAP_MIN);
      en_seen_q   <= 1'b0;
    end else begin
      if (ack_o) begin
        since_ack_q <= '0;
      end else if (since_ack_q < GAP_W'(GAP_MIN)) begin
        since_ack_q <= since_ack_q + GAP_W'(1);
      end
      if (ack_o) begin
        en_seen_q <= 1'b0;
      end else if (en_i) begin
        en_seen_q <= 1'b1;
      end
    end
  end

  // R2: acknowledge never lasts two cycles
  p_ack_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |=> !ack_o);

  // R2: every acknowledge was preceded by a request since the last one
  p_ack_has_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> en_seen_q);

  // R7: two acknowledges are at least LATENCY+2 cycles apart
  p_ack_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (since_ack_q >= GAP_W'(GAP_MIN)));

  // R3: read data moves only together with an acknowledge
  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rdata_o) |-> ack_o);

  // R8: a store acknowledge leaves read data alone
  p_store_keeps_rdata_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_o && acc_wr) |-> $stable(rdata_o));

endmodule

bind lat_line_mem lat_line_mem_chk #(
  .LATENCY (LATENCY),
  .LINE_W  (LINE_W)
) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .en_i    (mem_en_i),
  .ack_o   (mem_ack_o),
  .acc_wr  (acc_wr_q),
  .rdata_o (mem_rdata_o)
);

// File: tb/lat_line_mem_tb_top.sv
module lat_line_mem_tb_top;

  localparam int ADDR_W  = 32;
  localparam int LINE_W  = 256;
  localparam int DEPTH   = 512;
  localparam int LATENCY = 10;
  localparam int WD_MAX  = 5000;

  typedef struct {
    int                due;
    logic [LINE_W-1:0] data;
    string             tag;
  } exp_item_t;

  logic              clk;
  logic              rst_n;
  logic              en;
  logic              we;
  logic [ADDR_W-1:0] addr;
  logic [LINE_W-1:0] wdata;
  logic [LINE_W-1:0] rdata;
  logic              ack;

  int                checks = 0;
  int                errors = 0;
  int                cyc = 0;
  bit                mon_on = 0;
  exp_item_t         sb_q[$];
  logic [LINE_W-1:0] model [int];
  logic [LINE_W-1:0] last_rd = '0;

  lat_line_mem #(
    .ADDR_W  (ADDR_W),
    .LINE_W  (LINE_W),
    .DEPTH   (DEPTH),
    .LATENCY (LATENCY)
  ) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_en_i    (en),
    .mem_wr_i    (we),
    .mem_addr_i  (addr),
    .mem_wdata_i (wdata),
    .mem_rdata_o (rdata),
    .mem_ack_o   (ack)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int idx_of(logic [ADDR_W-1:0] a);
    return int'((a >> 5) % DEPTH);
  endfunction

  function automatic logic [LINE_W-1:0] pattern(int seed);
    logic [LINE_W-1:0] v;
    for (int k = 0; k < LINE_W / 32; k++) begin
      v[k*32 +: 32] = 32'h9E37_79B9 * (seed + 1) ^ (32'h0101_0101 * k);
    end
    return v;
  endfunction

  // driver: one request, optional noise on the inputs while busy (R6)
  task automatic issue(input logic wr, input logic [ADDR_W-1:0] a,
                       input logic [LINE_W-1:0] d, input bit noisy, input string tag);
    exp_item_t it;
    @(negedge clk);
    en = 1'b1; we = wr; addr = a; wdata = d;
    if (wr) begin
      model[idx_of(a)] = d;
    end else begin
      last_rd = model[idx_of(a)];
    end
    it.due  = cyc + 1 + LATENCY;
    it.data = last_rd;
    it.tag  = tag;
    sb_q.push_back(it);
    for (int j = 1; j <= LATENCY + 1; j++) begin
      @(negedge clk);
      if (noisy && j < LATENCY) begin
        en = j[0]; we = ~wr; addr = a ^ 32'h40; wdata = ~d;
      end else begin
        en = 1'b0; we = 1'b0; addr = '0; wdata = '0;
      end
    end
  endtask

  // R7: enable held high across three accesses
  task automatic hold_three(input logic [ADDR_W-1:0] a);
    exp_item_t it;
    int        n;
    @(negedge clk);
    n = cyc;
    en = 1'b1; we = 1'b0; addr = a;
    last_rd = model[idx_of(a)];
    for (int k = 0; k < 3; k++) begin
      it.due  = n + 1 + LATENCY + k * (LATENCY + 2);
      it.data = last_rd;
      it.tag  = "R7";
      sb_q.push_back(it);
    end
    repeat (2 * LATENCY + 5) @(negedge clk);
    en = 1'b0; addr = '0;
    repeat (LATENCY + 3) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++;
      $display("FAIL R7: pending acks %0d expected 0", sb_q.size());
    end
  endtask

  // monitor: compares every acknowledge with the scoreboard head
  initial begin
    exp_item_t it;
    forever begin
      @(negedge clk);
      if (mon_on && ack) begin
        if (sb_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R6: unexpected ack at cycle %0d expected none", cyc);
        end else begin
          it = sb_q.pop_front();
          checks++;
          if (cyc != it.due) begin
            errors++;
            $display("FAIL R2 (%s): ack at cycle %0d expected %0d", it.tag, cyc, it.due);
          end
          checks++;
          if (rdata !== it.data) begin
            errors++;
            $display("FAIL %s: rdata %h expected %h", it.tag, rdata, it.data);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc > WD_MAX);
    errors++;
    $display("FAIL R2: watchdog at cycle %0d expected below %0d", cyc, WD_MAX);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    checks++;
    if (ack !== 1'b0) begin
      errors++; $display("FAIL R1: ack %b expected 0 in reset", ack);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checks++;
    if (ack !== 1'b0 || rdata !== '0) begin
      errors++; $display("FAIL R1: ack %b rdata %h expected 0 and zero", ack, rdata);
    end
    mon_on = 1'b1;

    // R4: stores of full lines to several indices
    issue(1'b1, 32'h0000_0000, pattern(0), 1'b0, "R4");
    issue(1'b1, 32'h0000_0020, pattern(1), 1'b0, "R4");
    issue(1'b1, 32'h0000_0060, pattern(3), 1'b0, "R4");
    issue(1'b1, 32'h0000_00E0, pattern(7), 1'b0, "R4");
    issue(1'b1, 32'h0000_3FE0, pattern(511), 1'b0, "R4");

    // R3: loads return the stored lines
    issue(1'b0, 32'h0000_0060, '0, 1'b0, "R3");
    issue(1'b0, 32'h0000_3FE0, '0, 1'b0, "R3");
    issue(1'b0, 32'h0000_0000, '0, 1'b0, "R3");

    // R8: store acknowledge keeps the last loaded line on the output
    issue(1'b1, 32'h0000_00E0, pattern(70), 1'b0, "R8");
    issue(1'b0, 32'h0000_00E0, '0, 1'b0, "R4");

    // R3: output holds between acknowledges
    repeat (5) @(negedge clk);
    checks++;
    if (rdata !== last_rd) begin
      errors++; $display("FAIL R3: idle rdata %h expected %h", rdata, last_rd);
    end

    // R5: offset bits and bits above the index are ignored
    issue(1'b0, 32'h0000_007F, '0, 1'b0, "R5");
    issue(1'b0, 32'h0000_4060, '0, 1'b0, "R5");
    issue(1'b1, 32'hFFFF_C03F, pattern(90), 1'b0, "R5");
    issue(1'b0, 32'h0000_0020, '0, 1'b0, "R5");

    // R6: noise while busy changes nothing
    issue(1'b1, 32'h0000_0060, pattern(33), 1'b1, "R6");
    issue(1'b0, 32'h0000_0060, '0, 1'b1, "R6");
    issue(1'b0, 32'h0000_0020, '0, 1'b0, "R6");

    // R7: held enable, requests in ack cycles dropped
    hold_three(32'h0000_3FE0);

    repeat (4) @(negedge clk);
    checks++;
    if (sb_q.size() != 0) begin
      errors++; $display("FAIL R2: pending acks %0d expected 0", sb_q.size());
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule